// File: doc/BRIEF.md
# UART Channel Mode Loopback Router

This block sits between one UART channel's receiver and transmitter and the channel's serial pins. A two-bit mode input selects one of four operating modes. The block then steers the serial data, the bit-clock selection and the host-side ready and status flags to suit that mode. In normal operation the transmitter drives the pin and the receiver listens to the pin. In echo operation every received bit is re-timed and sent back out. Local loopback turns the transmitter back into the receiver for self-test. Remote loopback echoes the line back to the far end and hides the traffic from the host.

Re-timing is done by one register that captures the receiver's sampled bit on each receive bit tick. Parity, framing and break therefore go back out exactly as they came in. A mode change takes effect in the same clock cycle it is presented, even in the middle of a character. There is one exception. If an echoing mode is left while an echoed stop bit is still being sent, and the transmitter is enabled, the old mode stays in force until the last stop bit has gone out.

The baud generators, the FIFOs and the register interface lie outside the block. The receiver reports each sampled bit on `rx_tick`, along with a flag for the stop-bit sample, a break-detect pulse and a valid-start pulse.

Top module: `uart_mode_router`

## Requirements
- R1: With mode code 00 (normal), `txd` equals `tx_ser`, `rx_ser` equals `rxd`, both clock selects are 0, and every host flag equals its source flag.
- R2: With mode code 01 (echo), `txd` is the value of `rx_bit` captured at the last clock edge where `rx_tick` was 1, and it changes at no other edge. `tx_use_rxclk` is 1.
- R3: With mode code 01, `host_tx_rdy`, `host_tx_emt` and `tx_wr` are 0, while `host_rx_rdy` and `host_rx_err` still follow the receiver.
- R4: With mode code 10 (local loopback), `rx_ser` equals `tx_ser`, `txd` is 1, `rxd` has no effect on any output, and `rx_use_txclk` is 1.
- R5: With mode code 11 (remote loopback), `txd` carries the re-timed received bits as in R2, while `host_rx_rdy` and all bits of `host_rx_err` are 0.
- R6: In echo or remote mode, after a cycle with `rx_brk` = 1 the re-timed output is 0 at every tick, whatever `rx_bit` is, until a cycle with `rx_start_ok` = 1.
- R7: A change of `mode_sel` reaches the outputs in the same cycle when no stop bit is pending.
- R8: A tick with `rx_stop` = 1 in echo or remote mode arms a countdown of 1 tick, or 2 ticks when `stop_two` = 1. If `mode_sel` moves to 00 or 10 before the countdown ends and `tx_en` = 1, the echoing mode stays in effect until the countdown reaches zero.
- R9: With `tx_en` = 0, leaving echo or remote mode is immediate even if a stop bit is pending.
- R10: After reset, the re-timing register holds 1 (mark), no break is latched, no stop bit is pending, and the held mode is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Mode code: 00 normal, 01 echo, 10 local loop, 11 remote loop |
| tx_en | input | 1 | Transmitter enabled |
| stop_two | input | 1 | 1 when two stop bits are sent |
| rxd | input | 1 | Serial receive pin |
| txd | output | 1 | Serial transmit pin |
| tx_ser | input | 1 | Transmitter serial output |
| rx_ser | output | 1 | Serial input to the receiver |
| rx_use_txclk | output | 1 | Receiver runs from the transmit bit clock |
| tx_use_rxclk | output | 1 | Transmit side runs from the receive bit clock |
| rx_tick | input | 1 | Receiver sampled a bit this cycle |
| rx_bit | input | 1 | Value of the sampled bit |
| rx_stop | input | 1 | The sampled bit is the stop bit |
| rx_brk | input | 1 | Receiver detected a break |
| rx_start_ok | input | 1 | Receiver detected a valid start bit |
| rx_rdy_in | input | 1 | Receiver has data |
| rx_err_in | input | 3 | Receiver error flags |
| tx_rdy_in | input | 1 | Transmitter can accept data |
| tx_emt_in | input | 1 | Transmitter is empty |
| host_wr | input | 1 | Host write to the transmitter |
| host_rx_rdy | output | 1 | Receive-ready flag seen by the host |
| host_rx_err | output | 3 | Error flags seen by the host |
| host_tx_rdy | output | 1 | Transmit-ready flag seen by the host |
| host_tx_emt | output | 1 | Transmit-empty flag seen by the host |
| tx_wr | output | 1 | Write passed on to the transmitter |

## Verification
The block holds only four pieces of state: the re-timed bit, the break latch, the stop countdown and the held mode. A wrong value in any of them shows at `txd` or at a clock select within one receive bit time. A wrong re-timed bit or break latch shows at the next tick after a character begins. A wrong countdown shows as an early or late handover from echo to `tx_ser` at the first tick after a mode change. The bench compares every output on every clock against a behavioural model. Directed checks are placed on the tick edges where these mistakes would first appear.

// File: rtl/uart_mode_router.sv
module uart_mode_router #(
  parameter int ERR_W = 3,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             tx_en,
  input  logic             stop_two,
  input  logic             rxd,
  output logic             txd,
  input  logic             tx_ser,
  output logic             rx_ser,
  output logic             rx_use_txclk,
  output logic             tx_use_rxclk,
  input  logic             rx_tick,
  input  logic             rx_bit,
  input  logic             rx_stop,
  input  logic             rx_brk,
  input  logic             rx_start_ok,
  input  logic             rx_rdy_in,
  input  logic [ERR_W-1:0] rx_err_in,
  input  logic             tx_rdy_in,
  input  logic             tx_emt_in,
  input  logic             host_wr,
  output logic             host_rx_rdy,
  output logic [ERR_W-1:0] host_rx_err,
  output logic             host_tx_rdy,
  output logic             host_tx_emt,
  output logic             tx_wr
);
  localparam logic [1:0] M_NORM = 2'b00;
  localparam logic [1:0] M_ECHO = 2'b01;
  localparam logic [1:0] M_LOOP = 2'b10;
  localparam logic [1:0] M_RMT  = 2'b11;
  localparam logic [CNT_W-1:0] ONE_STOP = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO_STOP = CNT_W'(2);

  logic             echo_q;
  logic             brk_q;
  logic [CNT_W-1:0] stop_cnt_q;
  logic [1:0]       held_q;
  logic             hold_exit;
  logic [1:0]       eff;
  logic             retime;

  // an echoing mode (bit 0 set) is kept while its stop bit is still going out
  assign hold_exit = held_q[0] && !mode_sel[0] && (stop_cnt_q != '0) && tx_en;
  assign eff       = hold_exit ? held_q : mode_sel;
  assign retime    = eff[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      echo_q     <= 1'b1;
      brk_q      <= 1'b0;
      stop_cnt_q <= '0;
      held_q     <= M_NORM;
    end else begin
      held_q <= eff;
      if (rx_start_ok)
        brk_q <= 1'b0;
      else if (rx_brk)
        brk_q <= 1'b1;
      if (rx_tick) begin
        echo_q <= brk_q ? 1'b0 : rx_bit;
        if (rx_stop && retime)
          stop_cnt_q <= stop_two ? TWO_STOP : ONE_STOP;
        else if (stop_cnt_q != '0)
          stop_cnt_q <= stop_cnt_q - ONE_STOP;
      end
    end
  end

  always_comb begin
    txd          = tx_ser;
    rx_ser       = rxd;
    rx_use_txclk = 1'b0;
    tx_use_rxclk = 1'b0;
    host_rx_rdy  = rx_rdy_in;
    host_rx_err  = rx_err_in;
    host_tx_rdy  = tx_rdy_in;
    host_tx_emt  = tx_emt_in;
    tx_wr        = host_wr;
    unique case (eff)
      M_ECHO: begin
        txd          = echo_q;
        tx_use_rxclk = 1'b1;
        host_tx_rdy  = 1'b0;
        host_tx_emt  = 1'b0;
        tx_wr        = 1'b0;
      end
      M_LOOP: begin
        txd          = 1'b1;
        rx_ser       = tx_ser;
        rx_use_txclk = 1'b1;
      end
      M_RMT: begin
        txd          = echo_q;
        tx_use_rxclk = 1'b1;
        host_rx_rdy  = 1'b0;
        host_rx_err  = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/uart_mode_router_chk.sv
module uart_mode_router_chk #(
  parameter int ERR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_sel,
  input logic             rxd,
  input logic             txd,
  input logic             tx_ser,
  input logic             rx_ser,
  input logic             rx_use_txclk,
  input logic             tx_use_rxclk,
  input logic             rx_tick,
  input logic             host_rx_rdy,
  input logic [ERR_W-1:0] host_rx_err,
  input logic             host_tx_rdy,
  input logic             host_tx_emt,
  input logic             tx_wr
);
  assert_normal_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && !tx_use_rxclk) |-> (txd == tx_ser && rx_ser == rxd && !rx_use_txclk));

  assert_echo_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && tx_use_rxclk && $past(tx_use_rxclk) && !$past(rx_tick)) |-> $stable(txd));

  assert_echo_tx_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01) |-> (!host_tx_rdy && !host_tx_emt && !tx_wr));

  assert_local_loop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10 && !tx_use_rxclk) |-> (txd && rx_ser == tx_ser && rx_use_txclk));

  assert_remote_rx_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11) |-> (!host_rx_rdy && host_rx_err == '0 && tx_use_rxclk));
endmodule

bind uart_mode_router uart_mode_router_chk #(.ERR_W(ERR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rxd(rxd), .txd(txd),
  .tx_ser(tx_ser), .rx_ser(rx_ser), .rx_use_txclk(rx_use_txclk),
  .tx_use_rxclk(tx_use_rxclk), .rx_tick(rx_tick), .host_rx_rdy(host_rx_rdy),
  .host_rx_err(host_rx_err), .host_tx_rdy(host_tx_rdy), .host_tx_emt(host_tx_emt),
  .tx_wr(tx_wr)
);

// File: tb/uart_mode_router_tb.sv
module uart_mode_router_tb_top;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic tx_en = 1'b1, stop_two = 1'b0, rxd = 1'b1, tx_ser = 1'b1;
  logic rx_tick = 1'b0, rx_bit = 1'b1, rx_stop = 1'b0, rx_brk = 1'b0, rx_start_ok = 1'b0;
  logic rx_rdy_in = 1'b0, tx_rdy_in = 1'b0, tx_emt_in = 1'b0, host_wr = 1'b0;
  logic [2:0] rx_err_in = 3'b000;
  logic txd, rx_ser, rx_use_txclk, tx_use_rxclk;
  logic host_rx_rdy, host_tx_rdy, host_tx_emt, tx_wr;
  logic [2:0] host_rx_err;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  int m_echo, m_brk, m_cnt, m_held;

  always #(CLK_NS/2) clk = ~clk;

  uart_mode_router dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .tx_en(tx_en), .stop_two(stop_two),
    .rxd(rxd), .txd(txd), .tx_ser(tx_ser), .rx_ser(rx_ser),
    .rx_use_txclk(rx_use_txclk), .tx_use_rxclk(tx_use_rxclk),
    .rx_tick(rx_tick), .rx_bit(rx_bit), .rx_stop(rx_stop), .rx_brk(rx_brk),
    .rx_start_ok(rx_start_ok), .rx_rdy_in(rx_rdy_in), .rx_err_in(rx_err_in),
    .tx_rdy_in(tx_rdy_in), .tx_emt_in(tx_emt_in), .host_wr(host_wr),
    .host_rx_rdy(host_rx_rdy), .host_rx_err(host_rx_err), .host_tx_rdy(host_tx_rdy),
    .host_tx_emt(host_tx_emt), .tx_wr(tx_wr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: mode in force, then per-mode outputs
  function automatic int mode_now();
    if ((m_held == 1 || m_held == 3) && mode_sel[0] == 1'b0 && m_cnt > 0 && tx_en)
      return m_held;
    return int'(mode_sel);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_echo = 1; m_brk = 0; m_cnt = 0; m_held = 0;
    end else begin
      int md;
      md = mode_now();
      if (rx_tick) begin
        m_echo = (m_brk != 0) ? 0 : int'(rx_bit);
        if (rx_stop && (md == 1 || md == 3)) m_cnt = stop_two ? 2 : 1;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
      end
      if (rx_start_ok) m_brk = 0;
      else if (rx_brk) m_brk = 1;
      m_held = md;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int md;
      string tg;
      md = mode_now();
      tg = (md == 0) ? "R1 model txd" : (md == 1) ? "R2 model txd" :
           (md == 2) ? "R4 model txd" : "R5 model txd";
      chk(tg, txd, (md == 0) ? int'(tx_ser) : (md == 2) ? 1 : m_echo);
      chk("R4 model rx_ser", rx_ser, (md == 2) ? int'(tx_ser) : int'(rxd));
      chk("R4 model rx_use_txclk", rx_use_txclk, (md == 2) ? 1 : 0);
      chk("R8 model tx_use_rxclk", tx_use_rxclk, (md == 1 || md == 3) ? 1 : 0);
      chk("R3 model tx flags", {host_tx_rdy, host_tx_emt, tx_wr},
          (md == 1) ? 0 : int'({tx_rdy_in, tx_emt_in, host_wr}));
      chk("R5 model rx flags", {host_rx_rdy, host_rx_err},
          (md == 3) ? 0 : int'({rx_rdy_in, rx_err_in}));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic tick(input logic b, input logic stp);
    repeat (3) step();
    rx_tick = 1'b1; rx_bit = b; rx_stop = stp;
    step();
    rx_tick = 1'b0; rx_stop = 1'b0; rx_bit = 1'b1;
  endtask

  task automatic pulse_brk(); rx_brk = 1'b1; step(); rx_brk = 1'b0; endtask
  task automatic pulse_start(); rx_start_ok = 1'b1; step(); rx_start_ok = 1'b0; endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R10: echo selected across reset with tx_ser low; mark must appear
    mode_sel = 2'b01; tx_ser = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset txd mark", txd, 1);
    chk("R10 reset tx_use_rxclk", tx_use_rxclk, 1);
    step(); mode_sel = 2'b00;

    // R1 normal pass-through, several patterns
    tx_rdy_in = 1'b1; tx_emt_in = 1'b1; host_wr = 1'b1; rx_rdy_in = 1'b1; rx_err_in = 3'b101;
    for (int i = 0; i < 4; i++) begin
      tx_ser = i[0]; rxd = i[1];
      @(negedge clk);
      chk("R1 txd follows tx_ser", txd, int'(tx_ser));
      chk("R1 rx_ser follows rxd", rx_ser, int'(rxd));
      step();
    end
    chk("R1 host flags", {host_tx_rdy, host_tx_emt, tx_wr, host_rx_rdy}, 4'b1111);

    // R2/R3 echo of a character
    mode_sel = 2'b01; tx_ser = 1'b0;
    @(negedge clk);
    chk("R3 echo tx flags off", {host_tx_rdy, host_tx_emt, tx_wr}, 0);
    chk("R3 echo rx flags pass", {host_rx_rdy, host_rx_err}, 4'b1101);
    tick(1'b0, 1'b0);
    @(negedge clk); chk("R2 echo start bit", txd, 0);
    step(); step();
    @(negedge clk); chk("R2 echo held between ticks", txd, 0);
    tick(1'b1, 1'b0);
    @(negedge clk); chk("R2 echo data 1", txd, 1);
    tick(1'b0, 1'b0);
    tick(1'b1, 1'b1);
    @(negedge clk); chk("R2 echo stop bit", txd, 1);
    tick(1'b1, 1'b0);

    // R6 break echoed until valid start
    pulse_brk();
    tick(1'b1, 1'b0);
    @(negedge clk); chk("R6 break forces space", txd, 0);
    tick(1'b1, 1'b0);
    @(negedge clk); chk("R6 break still held", txd, 0);
    pulse_start();
    tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    @(negedge clk); chk("R6 break released after start", txd, 1);

    // R7 immediate change mid-character
    tick(1'b0, 1'b0);
    step(); mode_sel = 2'b00; tx_ser = 1'b1;
    @(negedge clk);
    chk("R7 immediate exit txd", txd, 1);
    chk("R7 immediate exit clock", tx_use_rxclk, 0);

    // R4 local loopback, rxd ignored
    step(); mode_sel = 2'b10; tx_ser = 1'b0; rxd = 1'b1;
    @(negedge clk);
    chk("R4 loop rx_ser from tx", rx_ser, 0);
    chk("R4 loop txd high", txd, 1);
    chk("R4 loop clock", rx_use_txclk, 1);
    step(); rxd = 1'b0; tx_ser = 1'b1;
    @(negedge clk);
    chk("R4 rxd ignored", rx_ser, 1);

    // R5 remote loopback
    step(); mode_sel = 2'b11; rx_err_in = 3'b111; rxd = 1'b1;
    @(negedge clk);
    chk("R5 remote rx flags hidden", {host_rx_rdy, host_rx_err}, 0);
    chk("R5 remote tx flags pass", host_tx_rdy, 1);
    tick(1'b0, 1'b0);
    @(negedge clk); chk("R5 remote echo", txd, 0);
    tick(1'b1, 1'b0);

    // R8 delayed exit, one stop bit, deselect one cycle after stop sample
    step(); mode_sel = 2'b01; tx_en = 1'b1; stop_two = 1'b0; tx_ser = 1'b0;
    tick(1'b0, 1'b0);
    tick(1'b1, 1'b1);
    step(); mode_sel = 2'b00;
    @(negedge clk);
    chk("R8 hold keeps echo txd", txd, 1);
    chk("R8 hold keeps rx clock", tx_use_rxclk, 1);
    tick(1'b1, 1'b0);
    @(negedge clk);
    chk("R8 released after stop", txd, 0);

    // R8 two stop bits
    step(); mode_sel = 2'b11; stop_two = 1'b1;
    tick(1'b0, 1'b0);
    tick(1'b1, 1'b1);
    step(); mode_sel = 2'b10;
    tick(1'b1, 1'b0);
    @(negedge clk);
    chk("R8 two stops still held", tx_use_rxclk, 1);
    tick(1'b1, 1'b0);
    @(negedge clk);
    chk("R8 two stops released", rx_use_txclk, 1);

    // R9 no hold without tx_en
    step(); mode_sel = 2'b01; stop_two = 1'b0; tx_en = 1'b0;
    tick(1'b0, 1'b0);
    tick(1'b1, 1'b1);
    step(); mode_sel = 2'b00;
    @(negedge clk);
    chk("R9 exit immediate", txd, 0);
    chk("R9 exit clock", tx_use_rxclk, 0);

    repeat (4) step();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule